// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar date as packed binary-coded decimal words. A slow kernel clock, typically 32.768 kHz, feeds a two-stage programmable down-counting divider. The first stage divides by `pre_a_i + 1`, and the second stage divides that tick by `pre_s_i + 1` to produce the one-second tick. With the usual programming of 127 and 255, a 32.768 kHz kernel clock gives exactly one tick per second. The second-stage count is visible on the outputs as a sub-second value with a resolution of 1/256 s.

Software holds `init_i` high while it sets the clock up. While init is high both divider stages sit at their reload values, and a load strobe copies new time and date words into the counters. When init is released, counting resumes from a full second. The hours counter runs either in 24-hour mode or in 12-hour mode, where a PM flag marks the afternoon. The date advances at midnight. The day-of-month rolls over at the end of each month, and February has 29 days in years divisible by four.

Top module: `bcd_calendar`

## Requirements
- R1: After synchronous reset the time word reads 00:00:00 with PM clear, the date reads day 01, month 01, year 00, weekday 1, and the sub-second output equals `pre_s_i`.
- R2: With init low, a seconds tick occurs once every (`pre_a_i`+1)·(`pre_s_i`+1) kernel cycles. The sub-second output counts down from `pre_s_i` to 0, stepping once every `pre_a_i`+1 cycles, and returns to `pre_s_i` on the tick.
- R3: While `init_i` is high both divider stages are held at their reload values, the sub-second output equals `pre_s_i`, and time and date do not advance.
- R4: A `load_i` strobe while `init_i` is high replaces the time and date words on the next clock edge. A strobe while `init_i` is low changes nothing.
- R5: Seconds and minutes each count 00 to 59 in BCD and wrap to 00, carrying one into the next field.
- R6: In 24-hour mode (`hour12_i`=0) hours run 00 to 23 and wrap to 00, advancing the date.
- R7: In 12-hour mode (`hour12_i`=1) hours run 01 to 12. Going from 11 to 12 toggles PM, going from 12 to 01 leaves PM alone, and the date advances when PM goes from 1 to 0.
- R8: The day-of-month wraps to 01 after the last day of the month (30 for April, June, September and November, 31 for the others). Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R9: February ends on day 29 when the two-digit year is divisible by 4 (00 included) and on day 28 otherwise.
- R10: The weekday, coded 1 to 7, increments each time the date advances and wraps from 7 to 1.
- R11: Time word layout: bit 20 PM, [19:18] hour tens, [17:14] hour units, [13:11] minute tens, [10:7] minute units, [6:4] second tens, [3:0] second units. Date word layout: [21:18] year tens, [17:14] year units, [13:11] weekday, bit 10 month tens, [9:6] month units, [5:4] day tens, [3:0] day units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_a_i | input | PRE_A_W (7) | First-stage divide value minus one |
| pre_s_i | input | PRE_S_W (15) | Second-stage divide value minus one |
| hour12_i | input | 1 | 1 selects 12-hour counting, 0 selects 24-hour |
| init_i | input | 1 | Init mode: dividers held, loads accepted |
| load_i | input | 1 | Load strobe for time and date words |
| load_time_i | input | 21 | Time word to load (layout R11) |
| load_date_i | input | 22 | Date word to load (layout R11) |
| time_o | output | 21 | Current packed BCD time |
| date_o | output | 22 | Current packed BCD date |
| subsec_o | output | PRE_S_W (15) | Second-stage down-count |

## Verification
The interesting coincidences are cascades that fall on a single seconds tick. On the last second of a year the seconds, minutes, hours, day, month, year and weekday all change on one edge. In 12-hour mode the PM flag toggles on the same edge that advances the date. The bench provokes each case by loading a state one or two seconds before the cascade, then running the dividers with small values. A behavioural model advances its own integer fields and compares every output against the design on every clock. Each case also ends with a pointed check of the packed words that the cascade should produce.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

    typedef struct packed {
        logic       pm;
        logic [1:0] hr_t;
        logic [3:0] hr_u;
        logic [2:0] mn_t;
        logic [3:0] mn_u;
        logic [2:0] sc_t;
        logic [3:0] sc_u;
    } cal_time_t;

    typedef struct packed {
        logic [3:0] yr_t;
        logic [3:0] yr_u;
        logic [2:0] wday;
        logic       mo_t;
        logic [3:0] mo_u;
        logic [1:0] dy_t;
        logic [3:0] dy_u;
    } cal_date_t;

    localparam int TIME_W = $bits(cal_time_t);
    localparam int DATE_W = $bits(cal_date_t);

    localparam logic [2:0] WDAY_FIRST = 3'd1;
    localparam logic [2:0] WDAY_LAST  = 3'd7;

    localparam logic [5:0] HR24_TOP   = 6'h23;
    localparam logic [5:0] HR12_PIVOT = 6'h11;
    localparam logic [5:0] HR12_TOP   = 6'h12;
    localparam logic [5:0] HR12_FIRST = 6'h01;
    localparam logic [4:0] MON_LAST   = 5'h12;
    localparam logic [4:0] MON_FIRST  = 5'h01;
    localparam logic [5:0] DAY_FIRST  = 6'h01;
    localparam logic [7:0] YEAR_LAST  = 8'h99;

    localparam cal_time_t TIME_RST = '{pm: 1'b0, hr_t: 2'd0, hr_u: 4'd0,
                                       mn_t: 3'd0, mn_u: 4'd0,
                                       sc_t: 3'd0, sc_u: 4'd0};
    localparam cal_date_t DATE_RST = '{yr_t: 4'd0, yr_u: 4'd0, wday: WDAY_FIRST,
                                       mo_t: 1'b0, mo_u: 4'd1,
                                       dy_t: 2'd0, dy_u: 4'd1};

    // Units digit reached nine: next step carries into the tens digit.
    function automatic logic digit_top(input logic [3:0] u);
        return u >= 4'd9;
    endfunction

    function automatic logic [3:0] digit_inc(input logic [3:0] u);
        return digit_top(u) ? 4'd0 : u + 4'd1;
    endfunction

    function automatic logic [5:0] bcd6_inc(input logic [5:0] v);
        return digit_top(v[3:0]) ? {v[5:4] + 2'd1, 4'd0} : {v[5:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd8_inc(input logic [7:0] v);
        return digit_top(v[3:0]) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Divisibility by four read straight off the BCD digits:
    // even tens need units 0/4/8, odd tens need units 2/6.
    function automatic logic year_leap(input logic tens_odd, input logic [3:0] units);
        if (tens_odd)
            return (units == 4'd2) || (units == 4'd6);
        return (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
    endfunction

    function automatic logic [5:0] month_last_day(input logic [4:0] mon,
                                                  input logic       tens_odd,
                                                  input logic [3:0] yr_units);
        case (mon)
            5'h02:                      return year_leap(tens_odd, yr_units) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler #(
    parameter int PRE_A_W = 7,
    parameter int PRE_S_W = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init_i,
    input  logic [PRE_A_W-1:0] pre_a_i,
    input  logic [PRE_S_W-1:0] pre_s_i,
    output logic               sec_tick_o,
    output logic [PRE_S_W-1:0] subsec_o
);

    logic [PRE_A_W-1:0] a_cnt;
    logic [PRE_S_W-1:0] s_cnt;
    logic               a_tick;

    assign a_tick     = !init_i && (a_cnt == '0);
    assign sec_tick_o = a_tick && (s_cnt == '0);
    assign subsec_o   = s_cnt;

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            a_cnt <= pre_a_i;
            s_cnt <= pre_s_i;
        end else if (a_tick) begin
            a_cnt <= pre_a_i;
            s_cnt <= (s_cnt == '0) ? pre_s_i : s_cnt - 1'b1;
        end else begin
            a_cnt <= a_cnt - 1'b1;
        end
    end

    // R3: init forces the second stage to its reload value
    a_r3_init_reload: assert property (@(posedge clk) disable iff (rst)
        init_i |=> (s_cnt == $past(pre_s_i)));

    // R2: the second stage only moves when the first stage expires
    a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
        (!init_i && a_cnt != '0) |=> $stable(s_cnt));

    // R2: after a seconds tick the sub-second count restarts
    a_r2_tick_reload: assert property (@(posedge clk) disable iff (rst)
        sec_tick_o |=> (s_cnt == $past(pre_s_i)));

endmodule

// File: rtl/cal_time_counter.sv
`timescale 1ns/1ps
module cal_time_counter
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  logic      hour12_i,
    input  logic      load_en_i,
    input  cal_time_t load_i,
    output cal_time_t time_o,
    output logic      day_adv_o
);

    cal_time_t  cur_q;
    cal_time_t  nxt;
    logic       sec_top;
    logic       min_top;
    logic [5:0] hr_bcd;
    logic [5:0] hr_next;
    logic       pm_next;
    logic       day_roll;

    always_comb begin
        sec_top  = (cur_q.sc_t >= 3'd5) && digit_top(cur_q.sc_u);
        min_top  = (cur_q.mn_t >= 3'd5) && digit_top(cur_q.mn_u);
        hr_bcd   = {cur_q.hr_t, cur_q.hr_u};
        hr_next  = hr_bcd;
        pm_next  = cur_q.pm;
        day_roll = 1'b0;
        if (hour12_i) begin
            if (hr_bcd == HR12_PIVOT) begin
                hr_next  = HR12_TOP;
                pm_next  = ~cur_q.pm;
                day_roll = cur_q.pm;
            end else if (hr_bcd >= HR12_TOP) begin
                hr_next  = HR12_FIRST;
            end else begin
                hr_next  = bcd6_inc(hr_bcd);
            end
        end else begin
            if (hr_bcd >= HR24_TOP) begin
                hr_next  = 6'h00;
                day_roll = 1'b1;
            end else begin
                hr_next  = bcd6_inc(hr_bcd);
            end
        end
    end

    always_comb begin
        nxt = cur_q;
        if (sec_top) begin
            nxt.sc_t = 3'd0;
            nxt.sc_u = 4'd0;
            if (min_top) begin
                nxt.mn_t = 3'd0;
                nxt.mn_u = 4'd0;
                {nxt.hr_t, nxt.hr_u} = hr_next;
                nxt.pm = pm_next;
            end else begin
                nxt.mn_u = digit_inc(cur_q.mn_u);
                if (digit_top(cur_q.mn_u))
                    nxt.mn_t = cur_q.mn_t + 3'd1;
            end
        end else begin
            nxt.sc_u = digit_inc(cur_q.sc_u);
            if (digit_top(cur_q.sc_u))
                nxt.sc_t = cur_q.sc_t + 3'd1;
        end
    end

    assign day_adv_o = tick_i && !load_en_i && sec_top && min_top && day_roll;
    assign time_o    = cur_q;

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= TIME_RST;
        else if (load_en_i)
            cur_q <= load_i;
        else if (tick_i)
            cur_q <= nxt;
    end

    // R4: without a tick or an accepted load the time word is frozen
    a_r4_time_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !load_en_i) |=> $stable(cur_q));

    // R5: a tick at second 59 leaves seconds at 00
    a_r5_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_en_i && cur_q.sc_t == 3'd5 && cur_q.sc_u == 4'd9)
        |=> (cur_q.sc_t == 3'd0 && cur_q.sc_u == 4'd0));

    // R6: 24-hour midnight lands on hour 00
    a_r6_midnight: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_en_i && !hour12_i && {cur_q.hr_t, cur_q.hr_u} == 6'h23
         && cur_q.mn_t == 3'd5 && cur_q.mn_u == 4'd9
         && cur_q.sc_t == 3'd5 && cur_q.sc_u == 4'd9)
        |=> ({cur_q.hr_t, cur_q.hr_u} == 6'h00));

    // R7: 11 -> 12 in 12-hour mode flips the PM flag
    a_r7_pm_flip: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_en_i && hour12_i && {cur_q.hr_t, cur_q.hr_u} == 6'h11
         && cur_q.mn_t == 3'd5 && cur_q.mn_u == 4'd9
         && cur_q.sc_t == 3'd5 && cur_q.sc_u == 4'd9)
        |=> (cur_q.pm != $past(cur_q.pm) && {cur_q.hr_t, cur_q.hr_u} == 6'h12));

endmodule

// File: rtl/cal_date_counter.sv
`timescale 1ns/1ps
module cal_date_counter
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv_i,
    input  logic      load_en_i,
    input  cal_date_t load_i,
    output cal_date_t date_o
);

    cal_date_t  cur_q;
    cal_date_t  nxt;
    logic [5:0] day_bcd;
    logic [4:0] mon_bcd;
    logic [7:0] yr_bcd;
    logic [5:0] last_day;
    logic       month_end;
    logic       year_end;

    always_comb begin
        day_bcd   = {cur_q.dy_t, cur_q.dy_u};
        mon_bcd   = {cur_q.mo_t, cur_q.mo_u};
        yr_bcd    = {cur_q.yr_t, cur_q.yr_u};
        last_day  = month_last_day(mon_bcd, cur_q.yr_t[0], cur_q.yr_u);
        month_end = day_bcd >= last_day;
        year_end  = mon_bcd >= MON_LAST;
    end

    always_comb begin
        nxt = cur_q;
        nxt.wday = (cur_q.wday >= WDAY_LAST) ? WDAY_FIRST : cur_q.wday + 3'd1;
        if (month_end) begin
            {nxt.dy_t, nxt.dy_u} = DAY_FIRST;
            if (year_end) begin
                {nxt.mo_t, nxt.mo_u} = MON_FIRST;
                {nxt.yr_t, nxt.yr_u} = (yr_bcd >= YEAR_LAST) ? 8'h00 : bcd8_inc(yr_bcd);
            end else if (digit_top(cur_q.mo_u)) begin
                nxt.mo_t = 1'b1;
                nxt.mo_u = 4'd0;
            end else begin
                nxt.mo_u = cur_q.mo_u + 4'd1;
            end
        end else begin
            {nxt.dy_t, nxt.dy_u} = bcd6_inc(day_bcd);
        end
    end

    assign date_o = cur_q;

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= DATE_RST;
        else if (load_en_i)
            cur_q <= load_i;
        else if (adv_i)
            cur_q <= nxt;
    end

    // R4: the date only changes on a day advance or an accepted load
    a_r4_date_hold: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !load_en_i) |=> $stable(cur_q));

    // R10: weekday 7 is followed by weekday 1
    a_r10_wday_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_en_i && cur_q.wday == 3'd7) |=> (cur_q.wday == 3'd1));

    // R8: the last day of December opens January the first
    a_r8_new_year: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_en_i && {cur_q.mo_t, cur_q.mo_u} == 5'h12
         && {cur_q.dy_t, cur_q.dy_u} == 6'h31)
        |=> ({cur_q.mo_t, cur_q.mo_u} == 5'h01 && {cur_q.dy_t, cur_q.dy_u} == 6'h01));

endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int PRE_A_W = 7,
    parameter int PRE_S_W = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PRE_A_W-1:0] pre_a_i,
    input  logic [PRE_S_W-1:0] pre_s_i,
    input  logic               hour12_i,
    input  logic               init_i,
    input  logic               load_i,
    input  logic [TIME_W-1:0]  load_time_i,
    input  logic [DATE_W-1:0]  load_date_i,
    output logic [TIME_W-1:0]  time_o,
    output logic [DATE_W-1:0]  date_o,
    output logic [PRE_S_W-1:0] subsec_o
);

    logic      sec_tick;
    logic      day_adv;
    logic      load_en;
    cal_time_t load_t;
    cal_date_t load_d;
    cal_time_t time_s;
    cal_date_t date_s;

    assign load_en = init_i && load_i;
    assign load_t  = load_time_i;
    assign load_d  = load_date_i;

    cal_prescaler #(
        .PRE_A_W (PRE_A_W),
        .PRE_S_W (PRE_S_W)
    ) u_presc (
        .clk        (clk),
        .rst        (rst),
        .init_i     (init_i),
        .pre_a_i    (pre_a_i),
        .pre_s_i    (pre_s_i),
        .sec_tick_o (sec_tick),
        .subsec_o   (subsec_o)
    );

    cal_time_counter u_time (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (sec_tick),
        .hour12_i  (hour12_i),
        .load_en_i (load_en),
        .load_i    (load_t),
        .time_o    (time_s),
        .day_adv_o (day_adv)
    );

    cal_date_counter u_date (
        .clk       (clk),
        .rst       (rst),
        .adv_i     (day_adv),
        .load_en_i (load_en),
        .load_i    (load_d),
        .date_o    (date_s)
    );

    assign time_o = time_s;
    assign date_o = date_s;

    // R3: no seconds tick is produced while init is held
    a_r3_no_tick_in_init: assert property (@(posedge clk) disable iff (rst)
        init_i |-> !sec_tick);

    // R4: a strobe outside init leaves both words untouched when no tick fires
    a_r4_load_ignored: assert property (@(posedge clk) disable iff (rst)
        (load_i && !init_i && !sec_tick) |=> ($stable(time_o) && $stable(date_o)));

endmodule

// File: tb/bcd_calendar_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_tb_top;

    localparam int AW = 7;
    localparam int SW = 15;
    localparam int TW = 21;
    localparam int DW = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [AW-1:0] pre_a;
    logic [SW-1:0] pre_s;
    logic          hour12, init, load;
    logic [TW-1:0] ld_time;
    logic [DW-1:0] ld_date;
    logic [TW-1:0] time_w;
    logic [DW-1:0] date_w;
    logic [SW-1:0] subsec;

    bcd_calendar dut_i (
        .clk         (clk),
        .rst         (rst),
        .pre_a_i     (pre_a),
        .pre_s_i     (pre_s),
        .hour12_i    (hour12),
        .init_i      (init),
        .load_i      (load),
        .load_time_i (ld_time),
        .load_date_i (ld_date),
        .time_o      (time_w),
        .date_o      (date_w),
        .subsec_o    (subsec)
    );

    int    checks = 0;
    int    failures = 0;
    bit    cmp_en = 0;
    bit    finished = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // reference model state
    int e_h, e_mi, e_s, e_pm, e_d, e_mo, e_y, e_wd, e_cnt, e_a, e_sd;
    int l_h, l_mi, l_s, l_pm, l_d, l_mo, l_y, l_wd;

    // R11 layouts
    function automatic logic [TW-1:0] mk_time(int h, int mi, int s, int pm);
        return {1'(pm), 2'(h / 10), 4'(h % 10), 3'(mi / 10), 4'(mi % 10), 3'(s / 10), 4'(s % 10)};
    endfunction

    function automatic logic [DW-1:0] mk_date(int d, int mo, int y, int wd);
        return {4'(y / 10), 4'(y % 10), 3'(wd), 1'(mo / 10), 4'(mo % 10), 2'(d / 10), 4'(d % 10)};
    endfunction

    function automatic int month_len(int mo, int y);
        case (mo)
            2:             return (y % 4 == 0) ? 29 : 28;
            4, 6, 9, 11:   return 30;
            default:       return 31;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic m_adv_day();
        e_wd = (e_wd == 7) ? 1 : e_wd + 1;
        if (e_d >= month_len(e_mo, e_y)) begin
            e_d = 1;
            if (e_mo == 12) begin
                e_mo = 1;
                e_y = (e_y + 1) % 100;
            end else begin
                e_mo++;
            end
        end else begin
            e_d++;
        end
    endtask

    task automatic m_adv_sec();
        e_s++;
        if (e_s == 60) begin
            e_s = 0;
            e_mi++;
            if (e_mi == 60) begin
                e_mi = 0;
                if (hour12) begin
                    if (e_h == 11) begin
                        e_h = 12;
                        e_pm = 1 - e_pm;
                        if (e_pm == 0) m_adv_day();
                    end else if (e_h == 12) begin
                        e_h = 1;
                    end else begin
                        e_h++;
                    end
                end else if (e_h == 23) begin
                    e_h = 0;
                    m_adv_day();
                end else begin
                    e_h++;
                end
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        e_a  = int'(pre_a);
        e_sd = int'(pre_s);
        if (rst) begin
            e_h = 0; e_mi = 0; e_s = 0; e_pm = 0;
            e_d = 1; e_mo = 1; e_y = 0; e_wd = 1; e_cnt = 0;
        end else if (init) begin
            e_cnt = 0;
            if (load) begin
                e_h = l_h; e_mi = l_mi; e_s = l_s; e_pm = l_pm;
                e_d = l_d; e_mo = l_mo; e_y = l_y; e_wd = l_wd;
            end
        end else begin
            e_cnt++;
            if (e_cnt % ((e_a + 1) * (e_sd + 1)) == 0) m_adv_sec();
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(cur_req, 32'(time_w), 32'(mk_time(e_h, e_mi, e_s, e_pm)));
            chk(cur_req, 32'(date_w), 32'(mk_date(e_d, e_mo, e_y, e_wd)));
            chk("R2 subsec", 32'(subsec),
                32'(e_sd - ((e_cnt % ((e_a + 1) * (e_sd + 1))) / (e_a + 1))));
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog all-requirements actual=%0d expected<=20000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_load(int h, int mi, int s, int pm, int d, int mo, int y, int wd, bit h12);
        init = 1'b1;
        hour12 = h12;
        l_h = h; l_mi = mi; l_s = s; l_pm = pm;
        l_d = d; l_mo = mo; l_y = y; l_wd = wd;
        ld_time = mk_time(h, mi, s, pm);
        ld_date = mk_date(d, mo, y, wd);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk("R4 R11 load time", 32'(time_w), 32'(mk_time(h, mi, s, pm)));
        chk("R4 R11 load date", 32'(date_w), 32'(mk_date(d, mo, y, wd)));
        init = 1'b0;
    endtask

    task automatic run_secs(int n);
        repeat (n * 6) @(negedge clk);
    endtask

    initial begin
        pre_a = 7'd3; pre_s = 15'd3;
        hour12 = 1'b0; init = 1'b0; load = 1'b0;
        ld_time = '0; ld_date = '0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 reset time", 32'(time_w), 32'(mk_time(0, 0, 0, 0)));
        chk("R1 reset date", 32'(date_w), 32'(mk_date(1, 1, 0, 1)));
        chk("R1 reset subsec", 32'(subsec), 32'd3);
        rst = 1'b0;
        cmp_en = 1'b1;

        // R2 second period with dividers 4 x 4
        cur_req = "R2";
        begin
            int n = 0;
            while (time_w == mk_time(0, 0, 0, 0) && n < 200) begin
                @(negedge clk);
                n++;
            end
            chk("R2 cycles per second", 32'(n), 32'd16);
        end
        repeat (5) @(negedge clk);
        chk("R2 subsec step", 32'(subsec), 32'd2);

        // R3 init holds the dividers and the time
        cur_req = "R3";
        init = 1'b1;
        pre_a = 7'd1;
        pre_s = 15'd2;
        repeat (40) @(negedge clk);
        chk("R3 time frozen", 32'(time_w), 32'(mk_time(0, 0, 1, 0)));
        chk("R3 subsec at reload", 32'(subsec), 32'd2);

        // R4 strobe outside init is ignored
        cur_req = "R4";
        init = 1'b0;
        ld_time = mk_time(7, 7, 7, 0);
        ld_date = mk_date(9, 9, 9, 5);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk("R4 ignored time", 32'(time_w), 32'(mk_time(0, 0, 1, 0)));
        chk("R4 ignored date", 32'(date_w), 32'(mk_date(1, 1, 0, 1)));

        // R5 minute carry
        cur_req = "R5";
        do_load(5, 59, 59, 0, 15, 8, 30, 2, 1'b0);
        run_secs(1);
        chk("R5 hour carry", 32'(time_w), 32'(mk_time(6, 0, 0, 0)));

        // R6 and R10 midnight in 24-hour mode, end of April, weekday 7
        cur_req = "R6";
        do_load(23, 59, 58, 0, 30, 4, 21, 7, 1'b0);
        run_secs(2);
        chk("R6 midnight", 32'(time_w), 32'(mk_time(0, 0, 0, 0)));
        chk("R10 weekday wrap", 32'(date_w), 32'(mk_date(1, 5, 21, 1)));

        // R7 12-hour mode
        cur_req = "R7";
        do_load(11, 59, 59, 0, 10, 3, 22, 3, 1'b1);
        run_secs(1);
        chk("R7 noon sets PM", 32'(time_w), 32'(mk_time(12, 0, 0, 1)));
        chk("R7 noon keeps date", 32'(date_w), 32'(mk_date(10, 3, 22, 3)));
        do_load(12, 59, 59, 1, 10, 3, 22, 3, 1'b1);
        run_secs(1);
        chk("R7 twelve to one", 32'(time_w), 32'(mk_time(1, 0, 0, 1)));
        do_load(11, 59, 59, 1, 31, 12, 99, 3, 1'b1);
        run_secs(1);
        chk("R7 midnight clears PM", 32'(time_w), 32'(mk_time(12, 0, 0, 0)));
        chk("R8 year 99 wraps", 32'(date_w), 32'(mk_date(1, 1, 0, 4)));

        // R8 31-day month
        cur_req = "R8";
        do_load(23, 59, 59, 0, 31, 1, 22, 5, 1'b0);
        run_secs(1);
        chk("R8 end of January", 32'(date_w), 32'(mk_date(1, 2, 22, 6)));

        // R9 February
        cur_req = "R9";
        do_load(23, 59, 59, 0, 28, 2, 24, 2, 1'b0);
        run_secs(1);
        chk("R9 leap 28th", 32'(date_w), 32'(mk_date(29, 2, 24, 3)));
        do_load(23, 59, 59, 0, 29, 2, 24, 3, 1'b0);
        run_secs(1);
        chk("R9 leap 29th", 32'(date_w), 32'(mk_date(1, 3, 24, 4)));
        do_load(23, 59, 59, 0, 28, 2, 23, 1, 1'b0);
        run_secs(1);
        chk("R9 common year", 32'(date_w), 32'(mk_date(1, 3, 23, 2)));
        do_load(23, 59, 59, 0, 28, 2, 0, 6, 1'b0);
        run_secs(1);
        chk("R9 year 00", 32'(date_w), 32'(mk_date(29, 2, 0, 7)));

        run_secs(2);
        cmp_en = 1'b0;
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule